// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block holds the configuration state of one plug-and-play expansion card. After power-up the card is locked and watches writes to a fixed address port for an unlock key. Two keys exist: the general one that any configuration software sends, and a vendor key that only a setup program sends. Once unlocked, the card steps through a sleep state, an isolation state and a configuration state under simple command writes. In the configuration state software programs the card's resources: I/O base address, interrupt level and type, DMA channel, two memory descriptor enables, a range-check control, a vendor byte and an activate bit.

Host I/O writes reach the block as a stream of (port, byte) beats. A beat on the address port selects a register index, or feeds the key matchers while the card is locked. A beat on the write-data port writes the selected register. The stream never applies back-pressure: `in_ready` is always high, and every cycle with `in_valid` high is one accepted beat. The outputs show the programmed resources and an `io_active` flag that enables the card's I/O decoder. Setting bit 6 of the vendor byte puts the card in legacy mode: from then on only the vendor key can unlock it, so generic configuration software cannot move its resources.

Top module: `pnpcfg_ctrl`

## Requirements
- R1: After reset `cfg_state` is 0 (locked), `card_num` is 0, `io_base` is 0, `io_active` is 0, `dma_chan` is 4 (no channel), every other resource output is 0 and `in_ready` is 1.
- R2: While locked, address-port bytes are compared with a 32-byte key that starts at 0x6A. Each following byte is the previous byte v shifted right one place, with v[0]^v[1] entering as the new bit 7. The last byte of a complete match moves `cfg_state` to 1 (sleep). A wrong byte restarts the match, and a wrong byte equal to 0x6A counts as the first byte of a new attempt.
- R3: A second key of the same form that starts at 0x6B always unlocks the card. The first key unlocks it only while bit 6 of the vendor byte is 0.
- R4: While locked, data-port writes change nothing, and address-port writes only feed the key matchers. They never change the register index.
- R5: Register 0x02 is accepted in sleep, isolation and configuration. Bit 0 returns every resource register to its reset value, including the vendor byte. Bit 2 clears `card_num`. Bit 1 returns `cfg_state` to 0.
- R6: A write of value w to register 0x03 (wake) compares w with `card_num`. If they are equal and w is 0, `cfg_state` becomes 2 (isolation). If they are equal and w is nonzero, it becomes 3 (configuration). If they differ, it becomes 1 (sleep).
- R7: A write to register 0x06 in isolation stores the card number and moves `cfg_state` to 3. In configuration the same write only stores the card number. In sleep it is ignored.
- R8: Resource registers are written only in configuration. The field map is: 0x60 sets `io_base`[15:8], 0x61 sets `io_base`[7:0], 0x30 bit 0 sets activate, 0x31 bits 1:0 set `range_ctl`, 0x43 bit 0 sets `mem0_en`, 0x4B bit 0 sets `mem1_en`, 0x70 bits 3:0 set `irq_level`, 0x71 bits 1:0 set `irq_type`, 0x74 bits 2:0 set `dma_chan`, and 0xF0 sets `vendor_byte`. Other indexes are ignored.
- R9: `io_active` is 1 only when the activate bit is set and `io_base` is nonzero.
- R10: The address port is 0x0279 and the write-data port is 0x0A79. Beats to any other port are ignored. An accepted beat shows its effect on the outputs right after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write beat present |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_port | input | 16 | I/O port address of the beat |
| in_data | input | 8 | Byte written |
| cfg_state | output | 2 | 0 locked, 1 sleep, 2 isolation, 3 configuration |
| card_num | output | 8 | Card select number |
| io_base | output | 16 | Programmed I/O base address |
| io_active | output | 1 | I/O decode enable |
| irq_level | output | 4 | Interrupt level |
| irq_type | output | 2 | Interrupt type |
| dma_chan | output | 3 | DMA channel (4 = none) |
| mem0_en | output | 1 | Memory descriptor 0 enable |
| mem1_en | output | 1 | Memory descriptor 1 enable |
| range_ctl | output | 2 | I/O range-check control |
| vendor_byte | output | 8 | Vendor byte; bit 6 is legacy mode |

## Verification
Directed sequences cover several cases:
- A full configuration pass through all four states.
- A key broken part-way, which tells a matcher that restarts apart from one that resumes.
- The general key sent with the legacy bit set, which tells key selection apart from plain matching.
- Activation before and after the base address is set.

Seeded random mixes of index writes, data writes, command values, both keys and stray ports are compared beat by beat against a bench model of the requirements. These mixes expose mistakes in which state accepts which write, and mistakes in the order in which commands take effect.

// File: rtl/pnpcfg_pkg.sv
package pnpcfg_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ISOL  = 2'd2,
    ST_CFG   = 2'd3
  } pnp_state_e;

  localparam logic [7:0] IDX_CTL   = 8'h02;
  localparam logic [7:0] IDX_WAKE  = 8'h03;
  localparam logic [7:0] IDX_CSN   = 8'h06;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_RCHK  = 8'h31;
  localparam logic [7:0] IDX_MEM0  = 8'h43;
  localparam logic [7:0] IDX_MEM1  = 8'h4B;
  localparam logic [7:0] IDX_BASEH = 8'h60;
  localparam logic [7:0] IDX_BASEL = 8'h61;
  localparam logic [7:0] IDX_IRQL  = 8'h70;
  localparam logic [7:0] IDX_IRQT  = 8'h71;
  localparam logic [7:0] IDX_DMA   = 8'h74;
  localparam logic [7:0] IDX_VND   = 8'hF0;

  localparam int         LEGACY_BIT = 6;
  localparam logic [2:0] DMA_NONE   = 3'd4;

  typedef struct packed {
    logic [15:0] base;
    logic        act;
    logic [1:0]  rchk;
    logic        mem0;
    logic        mem1;
    logic [3:0]  irq_lvl;
    logic [1:0]  irq_typ;
    logic [2:0]  dma;
    logic [7:0]  vendor;
  } cfg_regs_t;

  // One step of the key sequence generator
  function automatic logic [7:0] key_step(input logic [7:0] v);
    return {v[0] ^ v[1], v[7:1]};
  endfunction

  function automatic cfg_regs_t cfg_defaults();
    cfg_regs_t r;
    r     = '0;
    r.dma = DMA_NONE;
    return r;
  endfunction

endpackage

// File: rtl/pnpcfg_key_match.sv
module pnpcfg_key_match
  import pnpcfg_pkg::*;
#(
  parameter logic [7:0] SEED = 8'h6A,
  parameter int         LEN  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic [7:0] din,
  output logic       hit
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [7:0]    exp_q;
  logic [CW-1:0] cnt_q;
  logic          match, last;

  assign match = (din == exp_q);
  assign last  = (cnt_q == LAST);
  assign hit   = step & match & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= SEED;
      cnt_q <= '0;
    end else if (clr) begin
      exp_q <= SEED;
      cnt_q <= '0;
    end else if (step) begin
      if (match && !last) begin
        exp_q <= key_step(exp_q);
        cnt_q <= cnt_q + 1'b1;
      end else if (!match && din == SEED) begin
        exp_q <= key_step(SEED);
        cnt_q <= CW'(1);
      end else begin
        exp_q <= SEED;
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/pnpcfg_regs.sv
module pnpcfg_regs
  import pnpcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dev_rst,
  input  logic      wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output cfg_regs_t regs
);
  cfg_regs_t regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= cfg_defaults();
    end else if (dev_rst) begin
      regs_q <= cfg_defaults();
    end else if (wr_en) begin
      case (idx)
        IDX_BASEH: regs_q.base[15:8] <= wdata;
        IDX_BASEL: regs_q.base[7:0]  <= wdata;
        IDX_ACT:   regs_q.act        <= wdata[0];
        IDX_RCHK:  regs_q.rchk       <= wdata[1:0];
        IDX_MEM0:  regs_q.mem0       <= wdata[0];
        IDX_MEM1:  regs_q.mem1       <= wdata[0];
        IDX_IRQL:  regs_q.irq_lvl    <= wdata[3:0];
        IDX_IRQT:  regs_q.irq_typ    <= wdata[1:0];
        IDX_DMA:   regs_q.dma        <= wdata[2:0];
        IDX_VND:   regs_q.vendor     <= wdata;
        default: ;
      endcase
    end
  end

  assign regs = regs_q;
endmodule

// File: rtl/pnpcfg_ctrl.sv
module pnpcfg_ctrl
  import pnpcfg_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT = 16'h0279,
  parameter logic [15:0] DATA_PORT = 16'h0A79,
  parameter int          KEY_LEN   = 32,
  parameter logic [7:0]  STD_SEED  = 8'h6A,
  parameter logic [7:0]  VND_SEED  = 8'h6B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_port,
  input  logic [7:0]  in_data,
  output logic [1:0]  cfg_state,
  output logic [7:0]  card_num,
  output logic [15:0] io_base,
  output logic        io_active,
  output logic [3:0]  irq_level,
  output logic [1:0]  irq_type,
  output logic [2:0]  dma_chan,
  output logic        mem0_en,
  output logic        mem1_en,
  output logic [1:0]  range_ctl,
  output logic [7:0]  vendor_byte
);
  localparam int          NKEYS = 2;
  localparam logic [15:0] SEEDS = {VND_SEED, STD_SEED};

  pnp_state_e state_q, state_d;
  logic [7:0] csn_q, csn_d, idx_q;
  logic       is_addr, is_data, locked, key_en, key_ok, cmd_wr;
  logic       dev_rst, cfg_wr;
  logic [NKEYS-1:0] key_hit;
  cfg_regs_t  regs;

  assign in_ready = 1'b1;
  assign is_addr  = in_valid && (in_port == ADDR_PORT);
  assign is_data  = in_valid && (in_port == DATA_PORT);
  assign locked   = (state_q == ST_WAIT);
  assign key_en   = is_addr && locked;
  assign cmd_wr   = is_data && !locked;

  // key 0: general key; key 1: vendor key
  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    pnpcfg_key_match #(.SEED(SEEDS[8*k +: 8]), .LEN(KEY_LEN)) u_match (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!locked),
      .step (key_en),
      .din  (in_data),
      .hit  (key_hit[k])
    );
  end

  assign key_ok = key_hit[1] | (key_hit[0] & ~regs.vendor[LEGACY_BIT]);

  always_comb begin
    state_d = state_q;
    csn_d   = csn_q;
    dev_rst = 1'b0;
    cfg_wr  = 1'b0;
    if (key_en && key_ok) begin
      state_d = ST_SLEEP;
    end else if (cmd_wr) begin
      case (idx_q)
        IDX_CTL: begin
          dev_rst = in_data[0];
          if (in_data[2]) csn_d = '0;
          if (in_data[1]) state_d = ST_WAIT;
        end
        IDX_WAKE: begin
          if (in_data == csn_q) state_d = (in_data == 8'h00) ? ST_ISOL : ST_CFG;
          else                  state_d = ST_SLEEP;
        end
        IDX_CSN: begin
          if (state_q == ST_ISOL) begin
            csn_d   = in_data;
            state_d = ST_CFG;
          end else if (state_q == ST_CFG) begin
            csn_d = in_data;
          end
        end
        default: cfg_wr = (state_q == ST_CFG);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      csn_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      csn_q   <= csn_d;
      if (is_addr && !locked) idx_q <= in_data;
    end
  end

  pnpcfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .dev_rst(dev_rst),
    .wr_en  (cfg_wr),
    .idx    (idx_q),
    .wdata  (in_data),
    .regs   (regs)
  );

  assign cfg_state   = state_q;
  assign card_num    = csn_q;
  assign io_base     = regs.base;
  assign io_active   = regs.act & (|regs.base);
  assign irq_level   = regs.irq_lvl;
  assign irq_type    = regs.irq_typ;
  assign dma_chan    = regs.dma;
  assign mem0_en     = regs.mem0;
  assign mem1_en     = regs.mem1;
  assign range_ctl   = regs.rchk;
  assign vendor_byte = regs.vendor;
endmodule

// File: rtl/pnpcfg_chk.sv
module pnpcfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  st,
  input logic [7:0]  csn,
  input logic [15:0] base,
  input logic [7:0]  vnd
);
  // R2: the locked state is left only towards sleep
  a_r2_unlock_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 2'd0 && st != 2'd0) |-> st == 2'd1);

  // R4: nothing programmable changes while locked
  a_r4_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 2'd0) |-> ($stable(base) && $stable(csn) && $stable(vnd)));

  // R6: isolation is entered only by waking with card number 0
  a_r6_isol_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != 2'd2 && st == 2'd2) |-> ($past(st) != 2'd0 && csn == 8'h00));

  // R7: the card number changes only in isolation/configuration, or is cleared
  a_r7_csn_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(csn)) |-> ($past(st) == 2'd2 || $past(st) == 2'd3 || csn == 8'h00));

  // R8: the base address is written only in configuration, or reset to 0
  a_r8_base_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(base)) |-> ($past(st) == 2'd3 || base == 16'h0000));
endmodule

bind pnpcfg_ctrl pnpcfg_chk u_chk (
  .clk (clk),
  .rst_n(rst_n),
  .st  (cfg_state),
  .csn (card_num),
  .base(io_base),
  .vnd (vendor_byte)
);

// File: tb/pnpcfg_ctrl_tb.sv
`timescale 1ns/1ps
module pnpcfg_ctrl_tb;
  localparam logic [15:0] AP = 16'h0279;
  localparam logic [15:0] DP = 16'h0A79;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [15:0] in_port = '0;
  logic [7:0]  in_data = '0;
  logic in_ready, io_active, mem0_en, mem1_en;
  logic [1:0] cfg_state, irq_type, range_ctl;
  logic [7:0] card_num, vendor_byte;
  logic [15:0] io_base;
  logic [3:0] irq_level;
  logic [2:0] dma_chan;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pnpcfg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_port(in_port), .in_data(in_data), .cfg_state(cfg_state),
    .card_num(card_num), .io_base(io_base), .io_active(io_active),
    .irq_level(irq_level), .irq_type(irq_type), .dma_chan(dma_chan),
    .mem0_en(mem0_en), .mem1_en(mem1_en), .range_ctl(range_ctl),
    .vendor_byte(vendor_byte)
  );

  // Bench model built from the requirements
  int m_st, m_kcnt[2];
  logic [7:0] m_csn, m_idx, m_vnd, m_kexp[2];
  logic [15:0] m_base;
  logic m_act, m_mem0, m_mem1;
  logic [1:0] m_rchk, m_irqt;
  logic [3:0] m_irql;
  logic [2:0] m_dma;

  function automatic logic [7:0] nxt(input logic [7:0] v);
    return {v[0] ^ v[1], v[7:1]};
  endfunction

  function automatic logic [7:0] seed(input int k);
    return (k == 0) ? 8'h6A : 8'h6B;
  endfunction

  task automatic m_res_regs();
    m_base = '0; m_act = 0; m_rchk = '0; m_mem0 = 0; m_mem1 = 0;
    m_irql = '0; m_irqt = '0; m_dma = 3'd4; m_vnd = '0;
  endtask

  task automatic m_res_keys();
    for (int k = 0; k < 2; k++) begin m_kexp[k] = seed(k); m_kcnt[k] = 0; end
  endtask

  task automatic m_write(input logic [15:0] p, input logic [7:0] d);
    logic h[2];
    if (p == AP && m_st == 0) begin
      for (int k = 0; k < 2; k++) begin
        h[k] = 0;
        if (d == m_kexp[k]) begin
          if (m_kcnt[k] == 31) begin h[k] = 1; m_kexp[k] = seed(k); m_kcnt[k] = 0; end
          else begin m_kexp[k] = nxt(m_kexp[k]); m_kcnt[k]++; end
        end else if (d == seed(k)) begin m_kexp[k] = nxt(seed(k)); m_kcnt[k] = 1; end
        else begin m_kexp[k] = seed(k); m_kcnt[k] = 0; end
      end
      if (h[1] || (h[0] && !m_vnd[6])) m_st = 1;
    end else if (p == AP) begin
      m_idx = d;
    end else if (p == DP && m_st != 0) begin
      case (m_idx)
        8'h02: begin
          if (d[0]) m_res_regs();
          if (d[2]) m_csn = 0;
          if (d[1]) m_st = 0;
        end
        8'h03: m_st = (d == m_csn) ? ((d == 0) ? 2 : 3) : 1;
        8'h06: if (m_st == 2) begin m_csn = d; m_st = 3; end
               else if (m_st == 3) m_csn = d;
        default: if (m_st == 3) case (m_idx)
          8'h60: m_base[15:8] = d;
          8'h61: m_base[7:0] = d;
          8'h30: m_act = d[0];
          8'h31: m_rchk = d[1:0];
          8'h43: m_mem0 = d[0];
          8'h4B: m_mem1 = d[0];
          8'h70: m_irql = d[3:0];
          8'h71: m_irqt = d[1:0];
          8'h74: m_dma = d[2:0];
          8'hF0: m_vnd = d;
          default: ;
        endcase
      endcase
    end
    if (m_st != 0) m_res_keys();
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    logic [63:0] a, e;
    a = {in_ready, cfg_state, card_num, io_base, io_active, irq_level, irq_type,
         dma_chan, mem0_en, mem1_en, range_ctl, vendor_byte};
    e = {1'b1, 2'(m_st), m_csn, m_base, m_act & (m_base != 0), m_irql, m_irqt,
         m_dma, m_mem0, m_mem1, m_rchk, m_vnd};
    chk(a == e, tag, a, e);
  endtask

  task automatic wr(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_port = p; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    m_write(p, d);
  endtask

  task automatic send_key(input logic [7:0] s, input int n);
    logic [7:0] v;
    v = s;
    wr(AP, 8'h00); wr(AP, 8'h00);
    for (int i = 0; i < n; i++) begin wr(AP, v); v = nxt(v); end
  endtask

  function automatic logic [7:0] pick_idx();
    logic [7:0] t[14] = '{8'h02, 8'h03, 8'h06, 8'h30, 8'h31, 8'h43, 8'h4B,
                          8'h60, 8'h61, 8'h70, 8'h71, 8'h74, 8'hF0, 8'h20};
    return t[$urandom % 14];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = 0; m_csn = 0; m_idx = 0; m_res_regs(); m_res_keys();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(cfg_state == 0 && card_num == 0 && io_base == 0 && !io_active, "R1 state/base", {cfg_state, card_num, io_base}, 0);
    chk(dma_chan == 3'd4 && irq_level == 0 && vendor_byte == 0 && in_ready, "R1 dma/ready", {in_ready, dma_chan}, {1'b1, 3'd4});

    // R10 stray port ignored
    wr(16'h0A78, 8'h6A); chk_model("R10 stray port");
    // R4 locked: data writes ignored
    wr(DP, 8'h55); wr(AP, 8'h60); wr(DP, 8'h12);
    chk(cfg_state == 0 && io_base == 0, "R4 locked write", {cfg_state, io_base}, 0);

    // R2 broken key restarts
    send_key(8'h6A, 10); wr(AP, 8'h11);
    begin
      logic [7:0] v = 8'h6A;
      for (int i = 0; i < 10; i++) v = nxt(v);
      for (int i = 10; i < 32; i++) begin wr(AP, v); v = nxt(v); end
    end
    chk(cfg_state == 0, "R2 broken key", cfg_state, 0);
    send_key(8'h6A, 32);
    chk(cfg_state == 1, "R2 full key", cfg_state, 1);

    // R5/R6/R7 standard flow
    wr(AP, 8'h02); wr(DP, 8'h05); wr(AP, 8'h03); wr(DP, 8'h00);
    chk(cfg_state == 2, "R6 wake 0 isolation", cfg_state, 2);
    wr(AP, 8'h06); wr(DP, 8'h01);
    chk(cfg_state == 3 && card_num == 1, "R7 set csn", {cfg_state, card_num}, {2'd3, 8'd1});
    wr(AP, 8'h30); wr(DP, 8'h01);
    chk(!io_active, "R9 active without base", io_active, 0);
    wr(AP, 8'h60); wr(DP, 8'h03); wr(AP, 8'h61); wr(DP, 8'h40);
    chk(io_base == 16'h0340 && io_active, "R8 R9 base active", {io_active, io_base}, {1'b1, 16'h0340});
    wr(AP, 8'h70); wr(DP, 8'hF5); wr(AP, 8'h74); wr(DP, 8'hFA); wr(AP, 8'h43); wr(DP, 8'hFF);
    wr(AP, 8'hF0); wr(DP, 8'h40);
    chk(irq_level == 4'h5 && dma_chan == 3'd2 && mem0_en && vendor_byte == 8'h40,
        "R8 field map", {irq_level, dma_chan, mem0_en, vendor_byte}, {4'h5, 3'd2, 1'b1, 8'h40});
    wr(AP, 8'h02); wr(DP, 8'h02);
    chk(cfg_state == 0, "R5 return to locked", cfg_state, 0);
    wr(DP, 8'h00); chk_model("R4 locked data write");

    // R3 legacy: general key refused, vendor key accepted
    send_key(8'h6A, 32);
    chk(cfg_state == 0, "R3 legacy blocks key", cfg_state, 0);
    send_key(8'h6B, 32);
    chk(cfg_state == 1, "R3 vendor key", cfg_state, 1);

    // sleep behaviour
    wr(AP, 8'h60); wr(DP, 8'h12);
    chk(io_base == 16'h0340, "R8 sleep write ignored", io_base, 16'h0340);
    wr(AP, 8'h06); wr(DP, 8'h09);
    chk(card_num == 1 && cfg_state == 1, "R7 csn ignored in sleep", {cfg_state, card_num}, {2'd1, 8'd1});
    wr(AP, 8'h03); wr(DP, 8'h05);
    chk(cfg_state == 1, "R6 wake mismatch", cfg_state, 1);
    wr(DP, 8'h01);
    chk(cfg_state == 3, "R6 wake match config", cfg_state, 3);
    wr(AP, 8'h06); wr(DP, 8'h07);
    chk(card_num == 7 && cfg_state == 3, "R7 csn in config", {cfg_state, card_num}, {2'd3, 8'd7});
    wr(AP, 8'h02); wr(DP, 8'h04);
    chk(card_num == 0, "R5 clear csn", card_num, 0);
    wr(DP, 8'h01);
    chk(io_base == 0 && vendor_byte == 0 && dma_chan == 3'd4 && !io_active,
        "R5 device reset", {io_base, vendor_byte, dma_chan}, {16'h0, 8'h0, 3'd4});

    // random mix against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] d;
      op = $urandom % 9;
      d = ($urandom % 2) ? 8'($urandom % 4) : 8'($urandom);
      case (op)
        0: send_key(8'h6A, 32);
        1: send_key(8'h6B, 32);
        2, 3: wr(AP, pick_idx());
        4, 5, 6: wr(DP, d);
        7: wr(AP, d);
        default: wr(16'($urandom), d);
      endcase
      chk_model("RND R2 R3 R5 R6 R7 R8 R9 R10");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule